// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs a single coprocessor instruction through a cycle-by-cycle handshake with an attached coprocessor. It supports five operation classes: a register word sent to the coprocessor, a word read back from it, an internal coprocessor data operation, a multi-word load from memory into the coprocessor, and a multi-word store from the coprocessor to memory. Each cycle the sequencer presents at most one phase code on `cp_phase_o`, and the coprocessor answers in that same cycle on `cp_resp_i`.

While the coprocessor reports busy, the sequencer waits one idle cycle and then polls again. Before each poll it checks whether an interrupt is pending. If one is, it sends an interrupt phase and gives up the instruction, reporting the cause. For memory operations it drives a word address that starts at `addr_i` and steps by one word for as long as the coprocessor answers increment. It checks the start address and aborts if the address is not legal. It also keeps running counts of idle (internal) cycles and coprocessor cycles. Base-register writeback stays with the caller, because addressing is post-indexed from the given start address.

The memory request is a valid/ready channel. Once `mem_req_valid_o` is high, address, write flag and write data stay constant until the cycle in which `mem_req_ready_i` is high. There is exactly one response per accepted request, marked by `mem_rsp_valid_i`. The memory must not raise it before the request has been accepted, and it may delay it by any number of cycles. The sequencer cannot stall a response. Control and status pins are plain signals.

Top module: `cop_seq`

## Requirements
- R1: One cycle after `start_i` is sampled high with `busy_o` low, the sequencer presents the first-phase code 1 on `cp_phase_o`. `start_i` is ignored while `busy_o` is high. Operation codes on `op_i`: 0 = send word to coprocessor, 1 = read word from coprocessor, 2 = coprocessor data operation, 3 = load, 4 = store.
- R2: The coprocessor responds with 0 = done, 1 = busy, 2 = can't, 3 = increment. A busy response to phase 1 or 2 is followed by exactly one cycle with phase 0 (none), counted as an internal cycle. After that the sequencer re-polls with phase 2 (busy).
- R3: At a re-poll, if an interrupt is pending, the sequencer presents phase 3 (interrupt) instead of phase 2. In the next cycle it signals completion with the interrupt cause. A pending interrupt has no effect during the first phase.
- R4: Interrupt causes, in priority order:
  - `line_rst_n_i` low gives status 3.
  - `fiq_n_i` low with `fiq_mask_i` clear gives status 4.
  - `irq_n_i` low with `irq_mask_i` clear gives status 5.
  - A line whose mask is set is not pending.
- R5: A can't response to phase 1 or 2 completes the instruction with status 1 (undefined) and no coprocessor cycle. Operation codes 5 to 7 complete with status 1 and no phase at all.
- R6: A load does the following in order:
  - Presents phase 4 (transfer).
  - Reads memory at the start address.
  - Presents phase 5 (data) with the read word on `cp_wdata_o`.
  - While the response to that data phase is increment, it reads again at an address 4 bytes higher and presents another data phase.
- R7: A store presents phase 5 and takes `cp_rdata_i` as the word to write to memory. While that data-phase response is increment, the next word goes to an address 4 bytes higher.
- R8: The sequencer completes with status 2 (abort) and performs no phase and no memory access in two cases: a load whose start address has a bit set at or above bit 26, or a store whose start address has such a bit set or lies below 32.
- R9: A memory response with `mem_rsp_err_i` high ends the transfer at once with status 2. No further data phase or memory request follows.
- R10: After acceptance, a send-to-coprocessor operation finishes with one coprocessor cycle. A read-from-coprocessor operation finishes with one coprocessor cycle and then one internal cycle, and returns on `rd_word_o` the `cp_rdata_i` value that was accepted. Every idle wait cycle adds one to `icyc_cnt_o`.
- R11: A refused read-from-coprocessor operation returns 0xF0000000 on `rd_word_o`, so that the caller's condition flags read as set.
- R12: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, `mem_req_valid_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold their values into the next cycle.
- R13: `done_o` is a one-cycle pulse carrying `status_o` (0 = success). `busy_o` stays high from the accepting cycle through the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new instruction |
| op_i | input | 3 | Operation class |
| addr_i | input | AW | Start word address for load and store |
| src_i | input | DW | Word to send to the coprocessor |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| status_o | output | 3 | Completion status |
| rd_word_o | output | DW | Word read from the coprocessor |
| cp_phase_o | output | 3 | Phase code to the coprocessor, 0 when idle |
| cp_wdata_o | output | DW | Word to the coprocessor (source or loaded word) |
| cp_resp_i | input | 2 | Same-cycle coprocessor response |
| cp_rdata_i | input | DW | Word from the coprocessor |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Request byte address |
| mem_wdata_o | output | DW | Write word |
| mem_rsp_valid_i | input | 1 | Response for the accepted request |
| mem_rsp_err_i | input | 1 | Response reports an abort |
| mem_rsp_rdata_i | input | DW | Read word |
| line_rst_n_i | input | 1 | Reset request line, active low |
| fiq_n_i | input | 1 | Fast interrupt line, active low |
| irq_n_i | input | 1 | Normal interrupt line, active low |
| fiq_mask_i | input | 1 | Fast interrupt disable |
| irq_mask_i | input | 1 | Normal interrupt disable |
| icyc_cnt_o | output | CW | Running internal-cycle count |
| ccyc_cnt_o | output | CW | Running coprocessor-cycle count |

## Verification
The assertions check several rules on every cycle:
- the first phase follows an accepted start by one cycle;
- a busy answer always opens exactly one idle gap, followed by a busy or interrupt phase;
- an interrupt phase or a can't answer always closes the instruction in the next cycle with the matching status;
- a stalled memory request holds steady;
- completion is a single-cycle pulse.

Other behaviour only the bench scenarios can show: the word addresses and data that a load or store moves, the priority among the interrupt lines, aborts on illegal start addresses and on memory errors, the flag-preserving word of a refused read, and the exact counts of internal and coprocessor cycles.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;
  // phase codes presented to the coprocessor
  localparam logic [2:0] PH_NONE  = 3'd0;
  localparam logic [2:0] PH_FIRST = 3'd1;
  localparam logic [2:0] PH_BUSY  = 3'd2;
  localparam logic [2:0] PH_INTR  = 3'd3;
  localparam logic [2:0] PH_XFER  = 3'd4;
  localparam logic [2:0] PH_DATA  = 3'd5;

  // coprocessor responses
  localparam logic [1:0] RS_DONE = 2'd0;
  localparam logic [1:0] RS_BUSY = 2'd1;
  localparam logic [1:0] RS_CANT = 2'd2;
  localparam logic [1:0] RS_INC  = 2'd3;

  // operation classes
  localparam logic [2:0] OP_TOCP   = 3'd0;
  localparam logic [2:0] OP_FROMCP = 3'd1;
  localparam logic [2:0] OP_CDO    = 3'd2;
  localparam logic [2:0] OP_LOAD   = 3'd3;
  localparam logic [2:0] OP_STORE  = 3'd4;

  // completion status
  localparam logic [2:0] ST_OK    = 3'd0;
  localparam logic [2:0] ST_UNDEF = 3'd1;
  localparam logic [2:0] ST_ABORT = 3'd2;
  localparam logic [2:0] ST_RESET = 3'd3;
  localparam logic [2:0] ST_FIQ   = 3'd4;
  localparam logic [2:0] ST_IRQ   = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_WAIT, S_POLL, S_XFER, S_MREQ,
    S_MRSP, S_LDATA, S_SDATA, S_CC1, S_IC1, S_FIN
  } seq_state_e;
endpackage

// File: rtl/cop_seq_prio.sv
module cop_seq_prio
  import cop_seq_pkg::*;
(
  input  logic       line_rst_n_i,
  input  logic       fiq_n_i,
  input  logic       irq_n_i,
  input  logic       fiq_mask_i,
  input  logic       irq_mask_i,
  output logic       pend_o,
  output logic [2:0] cause_o
);
  always_comb begin
    pend_o  = 1'b1;
    cause_o = ST_OK;
    if (!line_rst_n_i)                 cause_o = ST_RESET;
    else if (!fiq_n_i && !fiq_mask_i)  cause_o = ST_FIQ;
    else if (!irq_n_i && !irq_mask_i)  cause_o = ST_IRQ;
    else                               pend_o  = 1'b0;
  end
endmodule

// File: rtl/cop_seq_agen.sv
module cop_seq_agen #(
  parameter int AW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32,
  parameter int STEP       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          illegal_o,
  output logic          vector_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (step_i) addr_o <= addr_o + AW'(STEP);
  end

  generate
    if (LEGAL_BITS < AW) begin : g_range
      assign illegal_o = |base_i[AW-1:LEGAL_BITS];
    end else begin : g_full
      assign illegal_o = 1'b0;
    end
  endgenerate

  assign vector_o = (base_i < AW'(VEC_BYTES));
endmodule

// File: rtl/cop_seq_cnt.sv
module cop_seq_cnt #(
  parameter int CW  = 16,
  parameter int NUM = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM-1:0]          inc_i,
  output logic [NUM-1:0][CW-1:0]  cnt_o
);
  generate
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_o[g] <= '0;
        else if (inc_i[g]) cnt_o[g] <= cnt_o[g] + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/cop_seq.sv
module cop_seq
  import cop_seq_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32,
  parameter int CW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] src_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    status_o,
  output logic [DW-1:0] rd_word_o,
  output logic [2:0]    cp_phase_o,
  output logic [DW-1:0] cp_wdata_o,
  input  logic [1:0]    cp_resp_i,
  input  logic [DW-1:0] cp_rdata_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic          mem_rsp_err_i,
  input  logic [DW-1:0] mem_rsp_rdata_i,
  input  logic          line_rst_n_i,
  input  logic          fiq_n_i,
  input  logic          irq_n_i,
  input  logic          fiq_mask_i,
  input  logic          irq_mask_i,
  output logic [CW-1:0] icyc_cnt_o,
  output logic [CW-1:0] ccyc_cnt_o
);
  localparam int STEP = DW / 8;
  localparam logic [DW-1:0] FLAG_WORD = {4'hF, {(DW-4){1'b0}}};

  seq_state_e    state;
  logic [2:0]    op_q;
  logic [DW-1:0] src_q, ld_q, st_q, rd_q;
  logic          inc_q;
  logic [2:0]    status_q;

  logic          pend;
  logic [2:0]    pend_cause;
  logic          ag_load, ag_step, ag_illegal, ag_vector;
  logic [AW-1:0] ag_addr;
  logic [1:0][CW-1:0] cnt;

  cop_seq_prio u_prio (
    .line_rst_n_i (line_rst_n_i),
    .fiq_n_i      (fiq_n_i),
    .irq_n_i      (irq_n_i),
    .fiq_mask_i   (fiq_mask_i),
    .irq_mask_i   (irq_mask_i),
    .pend_o       (pend),
    .cause_o      (pend_cause)
  );

  assign ag_load = (state == S_IDLE) && start_i;
  assign ag_step = ((state == S_LDATA) && (cp_resp_i == RS_INC)) ||
                   ((state == S_MRSP) && mem_rsp_valid_i && !mem_rsp_err_i &&
                    (op_q == OP_STORE) && inc_q);

  cop_seq_agen #(
    .AW(AW), .LEGAL_BITS(LEGAL_BITS), .VEC_BYTES(VEC_BYTES), .STEP(STEP)
  ) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ag_load),
    .base_i    (addr_i),
    .step_i    (ag_step),
    .addr_o    (ag_addr),
    .illegal_o (ag_illegal),
    .vector_o  (ag_vector)
  );

  cop_seq_cnt #(.CW(CW), .NUM(2)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i ({state == S_CC1, (state == S_WAIT) || (state == S_IC1)}),
    .cnt_o (cnt)
  );

  assign icyc_cnt_o = cnt[0];
  assign ccyc_cnt_o = cnt[1];

  // outputs decoded from the registered state
  always_comb begin
    case (state)
      S_FIRST: cp_phase_o = PH_FIRST;
      S_POLL:  cp_phase_o = pend ? PH_INTR : PH_BUSY;
      S_XFER:  cp_phase_o = PH_XFER;
      S_LDATA,
      S_SDATA: cp_phase_o = PH_DATA;
      default: cp_phase_o = PH_NONE;
    endcase
  end

  assign cp_wdata_o      = (state == S_LDATA) ? ld_q : src_q;
  assign mem_req_valid_o = (state == S_MREQ);
  assign mem_we_o        = (op_q == OP_STORE);
  assign mem_addr_o      = ag_addr;
  assign mem_wdata_o     = st_q;
  assign busy_o          = (state != S_IDLE);
  assign done_o          = (state == S_FIN);
  assign status_o        = status_q;
  assign rd_word_o       = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= OP_TOCP;
      src_q    <= '0;
      ld_q     <= '0;
      st_q     <= '0;
      rd_q     <= '0;
      inc_q    <= 1'b0;
      status_q <= ST_OK;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_i) begin
            op_q     <= op_i;
            src_q    <= src_i;
            rd_q     <= '0;
            status_q <= ST_OK;
            if (op_i > OP_STORE) begin
              status_q <= ST_UNDEF;
              state    <= S_FIN;
            end else if (((op_i == OP_LOAD) && ag_illegal) ||
                         ((op_i == OP_STORE) && (ag_illegal || ag_vector))) begin
              status_q <= ST_ABORT;
              state    <= S_FIN;
            end else begin
              state <= S_FIRST;
            end
          end
        end

        S_FIRST, S_POLL: begin
          if ((state == S_POLL) && pend) begin
            status_q <= pend_cause;
            state    <= S_FIN;
          end else begin
            case (cp_resp_i)
              RS_BUSY: state <= S_WAIT;
              RS_CANT: begin
                status_q <= ST_UNDEF;
                if (op_q == OP_FROMCP) rd_q <= FLAG_WORD;
                state <= S_FIN;
              end
              default: begin
                case (op_q)
                  OP_TOCP:   state <= S_CC1;
                  OP_FROMCP: begin
                    rd_q  <= cp_rdata_i;
                    state <= S_CC1;
                  end
                  OP_LOAD:   state <= S_XFER;
                  OP_STORE:  state <= S_SDATA;
                  default:   state <= S_FIN;
                endcase
              end
            endcase
          end
        end

        S_WAIT:  state <= S_POLL;
        S_XFER:  state <= S_MREQ;

        S_SDATA: begin
          st_q  <= cp_rdata_i;
          inc_q <= (cp_resp_i == RS_INC);
          state <= S_MREQ;
        end

        S_MREQ: if (mem_req_ready_i) state <= S_MRSP;

        S_MRSP: begin
          if (mem_rsp_valid_i) begin
            if (mem_rsp_err_i) begin
              status_q <= ST_ABORT;
              state    <= S_FIN;
            end else if (op_q == OP_LOAD) begin
              ld_q  <= mem_rsp_rdata_i;
              state <= S_LDATA;
            end else if (inc_q) begin
              state <= S_SDATA;
            end else begin
              state <= S_FIN;
            end
          end
        end

        S_LDATA: state <= (cp_resp_i == RS_INC) ? S_MREQ : S_FIN;
        S_CC1:   state <= (op_q == OP_FROMCP) ? S_IC1 : S_FIN;
        S_IC1:   state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cop_seq_chk.sv
module cop_seq_chk
  import cop_seq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [2:0]    status_o,
  input logic [2:0]    cp_phase_o,
  input logic [1:0]    cp_resp_i,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o
);
  // R1: a first phase only ever follows an accepted start
  a_r1_first_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase_o == PH_FIRST) |-> $past(start_i && !busy_o));

  // R2: a busy answer opens one idle cycle inside the instruction
  a_r2_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_phase_o == PH_FIRST || cp_phase_o == PH_BUSY) && cp_resp_i == RS_BUSY)
      |=> (cp_phase_o == PH_NONE) && busy_o);

  // R2: after that gap the block re-polls or signals an interrupt
  a_r2_repoll: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_phase_o == PH_FIRST || cp_phase_o == PH_BUSY) && cp_resp_i == RS_BUSY)
      |=> ##1 (cp_phase_o == PH_BUSY || cp_phase_o == PH_INTR));

  // R3: an interrupt phase closes the instruction with an interrupt cause
  a_r3_intr_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase_o == PH_INTR) |=> done_o &&
      (status_o == ST_RESET || status_o == ST_FIQ || status_o == ST_IRQ));

  // R5: a refusal closes the instruction as undefined
  a_r5_cant_undef: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_phase_o == PH_FIRST || cp_phase_o == PH_BUSY) && cp_resp_i == RS_CANT)
      |=> done_o && (status_o == ST_UNDEF));

  // R12: a stalled memory request is held steady
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o &&
      $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_we_o));

  // R13: completion is a single-cycle pulse within a busy window
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o ##1 !done_o);
endmodule

bind cop_seq cop_seq_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .status_o        (status_o),
  .cp_phase_o      (cp_phase_o),
  .cp_resp_i       (cp_resp_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o)
);

// File: tb/cop_seq_tb_top.sv
module cop_seq_tb_top;
  import cop_seq_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] addr_i = '0, src_i = '0;
  logic        busy_o, done_o;
  logic [2:0]  status_o, cp_phase_o;
  logic [31:0] rd_word_o, cp_wdata_o;
  logic [1:0]  cp_resp_i = '0;
  logic [31:0] cp_rdata_i = '0;
  logic        mem_req_valid_o, mem_we_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_rsp_valid_i = 1'b0, mem_rsp_err_i = 1'b0;
  logic [31:0] mem_rsp_rdata_i = '0;
  logic        line_rst_n_i = 1'b1, fiq_n_i = 1'b1, irq_n_i = 1'b1;
  logic        fiq_mask_i = 1'b0, irq_mask_i = 1'b0;
  logic [15:0] icyc_cnt_o, ccyc_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_seq dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [64];

  // scenario knobs
  int g_nb, g_nw, g_err_at, g_extra;
  logic [1:0]  g_final;
  logic [31:0] g_rdata;
  // observations
  int r_first, r_busy, r_intr, r_xfer, r_data, r_acc, r_addr_bad, r_unstable, r_di, r_dc;
  logic [31:0] r_status, r_rd;
  logic [31:0] r_ldw [8];
  bit r_timeout;

  function automatic int widx(input logic [31:0] a); return int'((a >> 2) & 32'd63); endfunction
  function automatic logic [31:0] init_word(input int i); return 32'h1000_0000 ^ (32'(i) * 32'h0101_0101); endfunction
  function automatic logic [31:0] st_word(input int i); return 32'hC0DE_0000 + 32'(i); endfunction
  function automatic int exp_icyc(input logic [2:0] k, input int nb); return nb + ((k == OP_FROMCP) ? 1 : 0); endfunction
  function automatic int exp_ccyc(input logic [2:0] k); return (k == OP_TOCP || k == OP_FROMCP) ? 1 : 0; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_knobs(input int nb, input int nw, input logic [1:0] fin, input int err_at);
    g_nb = nb; g_nw = nw; g_final = fin; g_err_at = err_at; g_extra = 0;
    g_rdata = 32'h3000_0000 + 32'(nb * 17 + nw);
  endtask

  task automatic run_op(input logic [2:0] kind, input logic [31:0] base);
    int polls_left, acc_idx, acc_delay;
    bit acc_pend, err_pend, done_seen, prev_hold;
    logic [31:0] rsp_word, prev_addr, ic0, cc0;
    r_first = 0; r_busy = 0; r_intr = 0; r_xfer = 0; r_data = 0; r_addr_bad = 0; r_unstable = 0;
    polls_left = g_nb; acc_idx = 0; acc_delay = 0; acc_pend = 0; err_pend = 0;
    done_seen = 0; prev_hold = 0; prev_addr = '0; rsp_word = '0;
    @(negedge clk);
    ic0 = 32'(icyc_cnt_o); cc0 = 32'(ccyc_cnt_o);
    start_i = 1'b1; op_i = kind; addr_i = base; src_i = 32'h5A5A_0000 ^ base;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (g_extra != 0 && cyc == 1) begin
        start_i = 1'b1; op_i = OP_STORE; addr_i = 32'h200;
      end else start_i = 1'b0;
      if (mem_req_valid_o && prev_hold && mem_addr_o != prev_addr) r_unstable++;
      mem_rsp_valid_i = 1'b0; mem_rsp_err_i = 1'b0;
      if (acc_pend) begin
        if (acc_delay == 0) begin
          mem_rsp_valid_i = 1'b1; mem_rsp_err_i = err_pend; mem_rsp_rdata_i = rsp_word; acc_pend = 0;
        end else acc_delay--;
      end
      mem_req_ready_i = 1'b0;
      if (mem_req_valid_o && !acc_pend) begin
        mem_req_ready_i = (($urandom % 3) != 0);
        if (mem_req_ready_i) begin
          if (mem_addr_o != base + 32'(4 * acc_idx)) r_addr_bad++;
          if (mem_we_o) mem[widx(mem_addr_o)] = mem_wdata_o;
          rsp_word = mem[widx(mem_addr_o)];
          err_pend = (acc_idx == g_err_at);
          acc_delay = int'($urandom % 3);
          acc_pend = 1; acc_idx++;
        end
      end
      prev_hold = mem_req_valid_o && !mem_req_ready_i; prev_addr = mem_addr_o;
      cp_resp_i = RS_DONE; cp_rdata_i = g_rdata;
      case (cp_phase_o)
        PH_FIRST, PH_BUSY: begin
          if (cp_phase_o == PH_FIRST) r_first++; else r_busy++;
          if (polls_left > 0) begin cp_resp_i = RS_BUSY; polls_left--; end
          else cp_resp_i = g_final;
        end
        PH_INTR: r_intr++;
        PH_XFER: r_xfer++;
        PH_DATA: begin
          if (r_data < 8) r_ldw[r_data] = cp_wdata_o;
          cp_rdata_i = st_word(r_data);
          r_data++;
          cp_resp_i = (r_data < g_nw) ? RS_INC : RS_DONE;
        end
        default: ;
      endcase
      if (done_o) begin
        done_seen = 1; r_status = 32'(status_o); r_rd = rd_word_o;
        break;
      end
      @(negedge clk);
    end
    r_acc = acc_idx;
    r_di = int'(32'(icyc_cnt_o) - ic0);
    r_dc = int'(32'(ccyc_cnt_o) - cc0);
    r_timeout = !done_seen;
    start_i = 1'b0; mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0; cp_resp_i = RS_DONE;
    if (r_timeout) chk("R13 completion seen", 32'd0, 32'd1);
    @(negedge clk);
    chk("R13 done is a pulse", 32'(done_o), 32'd0);
    chk("R13 idle after done", 32'(busy_o), 32'd0);
  endtask

  task automatic check_std(input logic [2:0] kind, input logic [31:0] base);
    chk("R13 status ok", r_status, 32'(ST_OK));
    chk("R1 one first phase", 32'(r_first), 32'd1);
    chk("R2 busy polls", 32'(r_busy), 32'(g_nb));
    chk("R10 internal cycles", 32'(r_di), 32'(exp_icyc(kind, g_nb)));
    chk("R10 coprocessor cycles", 32'(r_dc), 32'(exp_ccyc(kind)));
    chk("R12 stalled address steady", 32'(r_unstable), 32'd0);
    if (kind == OP_FROMCP) chk("R10 read word", r_rd, g_rdata);
    if (kind == OP_LOAD) begin
      chk("R6 transfer phase", 32'(r_xfer), 32'd1);
      chk("R6 data phases", 32'(r_data), 32'(g_nw));
      chk("R6 address steps", 32'(r_addr_bad), 32'd0);
      for (int i = 0; i < g_nw; i++)
        chk("R6 loaded word", r_ldw[i], mem[widx(base + 32'(4 * i))]);
    end
    if (kind == OP_STORE) begin
      chk("R7 accesses", 32'(r_acc), 32'(g_nw));
      chk("R7 address steps", 32'(r_addr_bad), 32'd0);
      for (int i = 0; i < g_nw; i++)
        chk("R7 stored word", mem[widx(base + 32'(4 * i))], st_word(i));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R13)
    chk("R13 reset busy", 32'(busy_o), 32'd0);
    chk("R13 reset done", 32'(done_o), 32'd0);
    chk("R2 reset phase", 32'(cp_phase_o), 32'(PH_NONE));
    chk("R12 reset request", 32'(mem_req_valid_o), 32'd0);
    chk("R10 reset counters", 32'(icyc_cnt_o) + 32'(ccyc_cnt_o), 32'd0);

    // directed main function
    set_knobs(0, 1, RS_DONE, -1); run_op(OP_TOCP, 32'h100);   check_std(OP_TOCP, 32'h100);
    set_knobs(2, 1, RS_DONE, -1); run_op(OP_FROMCP, 32'h100); check_std(OP_FROMCP, 32'h100);
    set_knobs(1, 1, RS_DONE, -1); run_op(OP_CDO, 32'h100);    check_std(OP_CDO, 32'h100);
    set_knobs(1, 3, RS_DONE, -1); run_op(OP_LOAD, 32'h140);   check_std(OP_LOAD, 32'h140);
    set_knobs(0, 4, RS_INC, -1);  run_op(OP_STORE, 32'h180);  check_std(OP_STORE, 32'h180);

    // R5 / R11: refused read-back
    set_knobs(1, 1, RS_CANT, -1); run_op(OP_FROMCP, 32'h100);
    chk("R5 refused status", r_status, 32'(ST_UNDEF));
    chk("R5 no coprocessor cycle", 32'(r_dc), 32'd0);
    chk("R11 flag word", r_rd, 32'hF000_0000);
    // R5: unknown operation code
    set_knobs(0, 1, RS_DONE, -1); run_op(3'd6, 32'h100);
    chk("R5 unknown op status", r_status, 32'(ST_UNDEF));
    chk("R5 unknown op no phase", 32'(r_first), 32'd0);

    // R3 / R4: interrupts at a re-poll
    set_knobs(3, 1, RS_DONE, -1); irq_n_i = 1'b0; run_op(OP_TOCP, 32'h100);
    chk("R3 interrupt phase", 32'(r_intr), 32'd1);
    chk("R3 no busy poll", 32'(r_busy), 32'd0);
    chk("R3 one idle cycle", 32'(r_di), 32'd1);
    chk("R4 irq cause", r_status, 32'(ST_IRQ));
    fiq_n_i = 1'b0; line_rst_n_i = 1'b0; run_op(OP_TOCP, 32'h100);
    chk("R4 reset line wins", r_status, 32'(ST_RESET));
    line_rst_n_i = 1'b1; run_op(OP_TOCP, 32'h100);
    chk("R4 fast over normal", r_status, 32'(ST_FIQ));
    fiq_mask_i = 1'b1; run_op(OP_TOCP, 32'h100);
    chk("R4 masked fast skipped", r_status, 32'(ST_IRQ));
    irq_mask_i = 1'b1; set_knobs(2, 1, RS_DONE, -1); run_op(OP_TOCP, 32'h100);
    chk("R4 all masked completes", r_status, 32'(ST_OK));
    chk("R4 all masked polls", 32'(r_busy), 32'd2);
    fiq_n_i = 1'b1; fiq_mask_i = 1'b0; irq_mask_i = 1'b0;
    set_knobs(0, 1, RS_DONE, -1); run_op(OP_TOCP, 32'h100);
    chk("R3 ignored at first phase", r_status, 32'(ST_OK));
    irq_n_i = 1'b1;

    // R8: start address checks
    set_knobs(0, 1, RS_DONE, -1); run_op(OP_STORE, 32'h10);
    chk("R8 store to vectors", r_status, 32'(ST_ABORT));
    chk("R8 no phase", 32'(r_first), 32'd0);
    chk("R8 no access", 32'(r_acc), 32'd0);
    run_op(OP_LOAD, 32'h10);
    chk("R8 load from vectors allowed", r_status, 32'(ST_OK));
    run_op(OP_LOAD, 32'h0400_0100);
    chk("R8 illegal load", r_status, 32'(ST_ABORT));
    chk("R8 illegal load no access", 32'(r_acc), 32'd0);
    run_op(OP_STORE, 32'h0800_0100);
    chk("R8 illegal store", r_status, 32'(ST_ABORT));

    // R9: memory error ends the stream
    set_knobs(0, 3, RS_DONE, 1); run_op(OP_LOAD, 32'h100);
    chk("R9 load abort status", r_status, 32'(ST_ABORT));
    chk("R9 load accesses", 32'(r_acc), 32'd2);
    chk("R9 load data phases", 32'(r_data), 32'd1);
    set_knobs(1, 3, RS_DONE, 0); run_op(OP_STORE, 32'h1C0);
    chk("R9 store abort status", r_status, 32'(ST_ABORT));
    chk("R9 store accesses", 32'(r_acc), 32'd1);

    // R1: start ignored while busy
    set_knobs(3, 1, RS_DONE, -1); g_extra = 1; run_op(OP_TOCP, 32'h100);
    chk("R1 second start ignored", 32'(r_first), 32'd1);
    chk("R1 original op intact", 32'(r_dc), 32'd1);
    g_extra = 0;

    // constrained random mix
    for (int t = 0; t < 40; t++) begin
      logic [2:0] k;
      logic [31:0] b;
      k = 3'($urandom % 5);
      b = 32'h100 + 32'(($urandom % 16) * 4);
      set_knobs(int'($urandom % 4), 1 + int'($urandom % 4), RS_DONE, -1);
      run_op(k, b);
      check_std(k, b);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule